// File: doc/BRIEF.md
# Unconditional Branch Next-PC Unit

This block keeps the program counter and the return-address register for a 32-bit fixed-width instruction set. On each clock edge where the instruction strobe is high, it looks at the instruction word. If the word is the unconditional displacement branch, the counter moves to the branch target. Otherwise the counter steps to the next word.

The branch word holds a signed 24-bit count of words. The block multiplies that count by four and sign-extends it to the full address width. Two flag bits pick one of four variants:

- The absolute flag chooses between a target relative to the current instruction address and a target at the displacement itself.
- The link flag, when set, also stores the address of the following instruction as the return address.

The block does not test any condition and writes no status bits. Callers see three outputs: the current PC, the saved return address, and a single-cycle taken flag. The taken flag rises in the same cycle as the PC update it belongs to.

Top module: `ubr_nextpc`

## Requirements
- R1: The word is a branch exactly when its bits [31:26] (LSB-first numbering) equal 18, that is, when `(word & 32'hFC000000) == 32'h48000000`. A word with any other value in those bits, such as 16 or 19, is not a branch.
- R2: For a valid branch with bit 1 at 0 (the relative form), the PC in the next cycle is the current PC plus the sign-extended value of `{word[25:2], 2'b00}`. The sum is taken modulo 2^ADDR_W and no overflow is flagged.
- R3: For a valid branch with bit 1 at 1 (the absolute form), the PC in the next cycle is the sign-extended value of `{word[25:2], 2'b00}` alone.
- R4: For a valid branch with bit 0 at 1 (the link form), the link output in the next cycle equals the current PC plus 4. The PC still moves to the target given by R2 or R3.
- R5: For a valid branch with bit 0 at 0, the link output keeps its value.
- R6: For a valid word that is not a branch, the PC advances by 4 modulo 2^ADDR_W, the link output keeps its value, and the taken flag stays low.
- R7: While the strobe is low, the PC and the link output hold their values and the taken flag stays low, even if the word is a branch.
- R8: The taken flag is high for exactly the one cycle in which the PC shows the target of a branch accepted at the previous edge.
- R9: A synchronous active-high reset sets the PC to RESET_VEC, clears the link output to zero and clears the taken flag.
- R10: Every branch target is 4-byte aligned. The relative reach extends to −2^25 bytes at the low end and to 2^25−4 bytes at the high end.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| insn_vld | input | 1 | The instruction word is presented this cycle |
| insn_word | input | 32 | Instruction word to decode |
| pc_o | output | ADDR_W | Current program counter |
| link_o | output | ADDR_W | Saved return address |
| taken_o | output | 1 | High for the cycle after a branch is executed |

## Verification
Several properties are checked on every cycle by the assertions:

- the hold while the strobe is low;
- the step of 4 for non-branch words;
- the return address written as the old PC plus 4, and the link held when the link bit is clear;
- the pairing of the taken flag with an accepted branch;
- the alignment of the PC and of the target.

Only the bench scenarios can show the actual target values of the four variants, the two ends of the displacement reach, wrap-around past the top of the address space, and the rejection of neighbouring opcodes. Each of these depends on a specific input pattern.

// File: rtl/ubr_pkg.sv
package ubr_pkg;
   localparam int INSN_W     = 32;
   localparam int WORDS_W    = 24;
   localparam int DISP_W     = WORDS_W + 2;
   localparam logic [5:0] OPC_UBR = 6'd18;

   typedef struct packed {
      logic                is_br;
      logic                abs_sel;
      logic                link_sel;
      logic [WORDS_W-1:0]  words;
   } br_fields_t;
endpackage

// File: rtl/ubr_decode.sv
module ubr_decode
   import ubr_pkg::*;
(
   input  logic [INSN_W-1:0] word_i,
   output br_fields_t        fld_o
);
   always_comb begin
      fld_o.is_br    = (word_i[31:26] == OPC_UBR);
      fld_o.abs_sel  = word_i[1];
      fld_o.link_sel = word_i[0];
      fld_o.words    = word_i[25:2];
   end

   always_comb begin
      // R1
      decode_opc_chk: assert (fld_o.is_br == ((word_i & 32'hFC00_0000) == 32'h4800_0000));
   end
endmodule

// File: rtl/ubr_target.sv
module ubr_target
   import ubr_pkg::*;
#(
   parameter int ADDR_W = 64
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [ADDR_W-1:0]   pc_i,
   input  br_fields_t          fld_i,
   output logic [ADDR_W-1:0]   target_o
);
   logic [ADDR_W-1:0] disp;
   logic [DISP_W-1:0] raw;

   assign raw = {fld_i.words, 2'b00};

   generate
      if (ADDR_W == DISP_W) begin : g_narrow
         assign disp = raw;
      end else begin : g_wide
         assign disp = {{(ADDR_W-DISP_W){raw[DISP_W-1]}}, raw};
      end
   endgenerate

   always_comb begin
      if (fld_i.abs_sel) target_o = disp;
      else               target_o = pc_i + disp;
   end

   // R10
   target_align_chk: assert property (@(posedge clk) disable iff (rst)
      target_o[1:0] == 2'b00);
endmodule

// File: rtl/ubr_state.sv
module ubr_state
   import ubr_pkg::*;
#(
   parameter int                ADDR_W    = 64,
   parameter logic [ADDR_W-1:0] RESET_VEC = '0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                vld_i,
   input  br_fields_t          fld_i,
   input  logic [ADDR_W-1:0]   target_i,
   output logic [ADDR_W-1:0]   pc_o,
   output logic [ADDR_W-1:0]   link_o,
   output logic                taken_o
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

   logic [ADDR_W-1:0] seq_pc;
   logic              fire;

   assign seq_pc = pc_o + STEP;
   assign fire   = vld_i & fld_i.is_br;

   always_ff @(posedge clk) begin
      if (rst) begin
         pc_o    <= RESET_VEC;
         link_o  <= '0;
         taken_o <= 1'b0;
      end else begin
         taken_o <= fire;
         if (vld_i) begin
            pc_o <= fire ? target_i : seq_pc;
            if (fire && fld_i.link_sel) link_o <= seq_pc;
         end
      end
   end

   // R7
   idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !vld_i |=> ($stable(pc_o) && $stable(link_o) && !taken_o));
   // R6
   seq_step_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && !fld_i.is_br) |=> (pc_o == $past(pc_o) + STEP && $stable(link_o)));
   // R4
   link_write_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && fld_i.is_br && fld_i.link_sel) |=> (link_o == $past(pc_o) + STEP));
   // R5
   link_keep_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && fld_i.is_br && !fld_i.link_sel) |=> $stable(link_o));
   // R8
   taken_pulse_chk: assert property (@(posedge clk) disable iff (rst)
      (vld_i && fld_i.is_br) |=> (taken_o && pc_o == $past(target_i)));
   // R8
   taken_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      !(vld_i && fld_i.is_br) |=> !taken_o);
   // R10
   pc_align_chk: assert property (@(posedge clk) disable iff (rst)
      pc_o[1:0] == 2'b00);
endmodule

// File: rtl/ubr_nextpc.sv
module ubr_nextpc
   import ubr_pkg::*;
#(
   parameter int                ADDR_W    = 64,
   parameter logic [ADDR_W-1:0] RESET_VEC = ADDR_W'(32'h0010_0000)
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                insn_vld,
   input  logic [31:0]         insn_word,
   output logic [ADDR_W-1:0]   pc_o,
   output logic [ADDR_W-1:0]   link_o,
   output logic                taken_o
);
   generate
      if (ADDR_W < DISP_W) begin : g_bad_width
         $error("ubr_nextpc: ADDR_W must cover the 26-bit displacement");
      end
      if (RESET_VEC[1:0] != 2'b00) begin : g_bad_vec
         $error("ubr_nextpc: RESET_VEC must be word aligned");
      end
   endgenerate

   br_fields_t        fld;
   logic [ADDR_W-1:0] target;

   ubr_decode u_dec (
      .word_i (insn_word),
      .fld_o  (fld)
   );

   ubr_target #(.ADDR_W(ADDR_W)) u_tgt (
      .clk      (clk),
      .rst      (rst),
      .pc_i     (pc_o),
      .fld_i    (fld),
      .target_o (target)
   );

   ubr_state #(.ADDR_W(ADDR_W), .RESET_VEC(RESET_VEC)) u_st (
      .clk      (clk),
      .rst      (rst),
      .vld_i    (insn_vld),
      .fld_i    (fld),
      .target_i (target),
      .pc_o     (pc_o),
      .link_o   (link_o),
      .taken_o  (taken_o)
   );

   // R9
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (pc_o == RESET_VEC && link_o == '0 && !taken_o));
endmodule

// File: tb/sim_ubr_nextpc.sv
`timescale 1ns/1ps
module sim_ubr_nextpc;
   localparam int AW = 64;
   localparam logic [AW-1:0] RV = 64'h0000_0000_0010_0000;

   logic          clk = 1'b0;
   logic          rst;
   logic          insn_vld;
   logic [31:0]   insn_word;
   logic [AW-1:0] pc_o, link_o;
   logic          taken_o;

   int checks = 0;
   int failures = 0;
   logic [AW-1:0] e_pc, e_lr;
   logic          e_tk;

   always #2 clk = ~clk;

   ubr_nextpc #(.ADDR_W(AW), .RESET_VEC(RV)) u0 (
      .clk(clk), .rst(rst), .insn_vld(insn_vld), .insn_word(insn_word),
      .pc_o(pc_o), .link_o(link_o), .taken_o(taken_o)
   );

   function automatic logic [31:0] mk_br(input logic signed [23:0] w, input logic a, input logic l);
      return {6'd18, w, a, l};
   endfunction

   function automatic logic [AW-1:0] sx(input logic [23:0] w);
      logic [AW-1:0] r;
      r = {{(AW-24){w[23]}}, w};
      return r << 2;
   endfunction

   task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk({tag, " pc"}, pc_o, e_pc);
      chk({tag, " link"}, link_o, e_lr);
      chk({tag, " taken"}, {63'd0, taken_o}, {63'd0, e_tk});
   endtask

   task automatic step(input logic v, input logic [31:0] w, input string tag);
      logic br;
      @(negedge clk);
      insn_vld = v; insn_word = w;
      br = (w[31:26] == 6'd18);
      e_tk = v && br;
      if (v) begin
         if (br && w[0]) e_lr = e_pc + 4;
         if (br) e_pc = w[1] ? sx(w[25:2]) : e_pc + sx(w[25:2]);
         else    e_pc = e_pc + 4;
      end
      @(posedge clk); #1;
      check_all(tag);
      @(negedge clk);
      insn_vld = 1'b0;
      @(posedge clk); #1;
      e_tk = 1'b0;
      chk({tag, " taken drop R8"}, {63'd0, taken_o}, 64'd0);
   endtask

   task automatic t_reset;
      rst = 1'b1; insn_vld = 1'b0; insn_word = '0;
      repeat (3) @(posedge clk); #1;
      e_pc = RV; e_lr = '0; e_tk = 1'b0;
      check_all("R9 reset");
      @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_rel;
      step(1, mk_br(24'sd16, 0, 0), "R2 b fwd");
      chk("R2 fwd value", pc_o, RV + 64);
      step(1, mk_br(-24'sd8, 0, 0), "R2 b back");
      chk("R2 back value", pc_o, RV + 32);
   endtask

   task automatic t_link;
      logic [AW-1:0] p;
      p = pc_o;
      step(1, mk_br(24'sd100, 0, 1), "R4 bl");
      chk("R4 bl link", link_o, p + 4);
      step(1, mk_br(24'sd4, 0, 0), "R5 b keeps link");
      chk("R5 link held", link_o, p + 4);
   endtask

   task automatic t_abs;
      step(1, mk_br(24'sd4096, 1, 0), "R3 ba");
      chk("R3 ba value", pc_o, 64'h4000);
      step(1, mk_br(24'sd64, 1, 1), "R3 R4 bla");
      chk("R4 bla link", link_o, 64'h4004);
      chk("R3 bla value", pc_o, 64'h100);
   endtask

   task automatic t_nonbr;
      step(1, 32'h4C00_0020, "R1 R6 opc19");
      step(1, 32'h4000_0000, "R1 R6 opc16");
      step(1, 32'h7C00_0000, "R6 other");
   endtask

   task automatic t_idle;
      step(0, mk_br(24'sd1000, 0, 1), "R7 idle br");
      step(0, 32'h6000_0000, "R7 idle nop");
   endtask

   task automatic t_reach;
      logic [AW-1:0] p;
      step(1, mk_br(24'sd4096, 1, 0), "R10 setup");
      p = pc_o;
      step(1, mk_br(24'h7FFFFF, 0, 0), "R10 max reach");
      chk("R10 max delta", pc_o - p, 64'd33554428);
      p = pc_o;
      step(1, mk_br(24'h800000, 0, 0), "R10 min reach");
      chk("R10 min delta", p - pc_o, 64'd33554432);
   endtask

   task automatic t_wrap;
      step(1, mk_br(24'h800000, 1, 0), "R3 ba negative");
      chk("R3 neg abs", pc_o, 64'hFFFF_FFFF_FE00_0000);
      step(1, mk_br(24'h7FFFFF, 0, 0), "R2 to top");
      chk("R2 top", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
      step(1, 32'h6000_0000, "R6 wrap seq");
      chk("R6 wrapped", pc_o, 64'd0);
      step(1, mk_br(-24'sd1, 0, 0), "R2 wrap back");
      chk("R2 wrapped", pc_o, 64'hFFFF_FFFF_FFFF_FFFC);
   endtask

   initial begin
      fork
         begin
            t_reset; t_rel; t_link; t_abs; t_nonbr; t_idle; t_reach; t_wrap;
            t_reset;
         end
         begin
            repeat (20000) @(posedge clk);
            failures++;
            $display("FAIL watchdog act=hung exp=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule